// File: doc/BRIEF.md
# Advanced Load Alias Table

This block lets a scheduler move a load above stores that might write the same memory. When such a hoisted load issues, it arms a table entry. The entry records the load's destination register and the address it read. Every store that follows is compared in parallel against all armed entries. A store that writes into the same aligned 8-byte block as an armed entry disarms that entry.

Later, at the load's original place in the program, a check names the destination register. If the entry is still armed and belongs to that register, the check retires as a no-op. If not, the block does one of two things, chosen per check. It either asks memory to perform the load again, giving the recorded address and register, or it asks the front end to redirect to recovery code.

The table holds a power-of-two number of entries, selected by a fold of the register number. A later hoisted load whose register folds to the same slot replaces the older entry. A check gets its answer as a one-cycle pulse on the clock edge after the request.

Top module: `adv_load_alias_table`

## Requirements
- R1: After synchronous active-low reset every entry is disarmed and `chk_ok`, `reload_valid` and `redirect_valid` are low, with all reload and redirect data outputs at zero. A check issued straight after reset is therefore answered as aliased.
- R2: A hoisted load (`adv_valid`) with register r and address a arms slot h(r). For the default 7-bit register and 16 slots, h(r) = r[3:0] XOR {1'b0, r[6:4]}. A later check on r with no aliasing store in between raises `chk_ok` for exactly one cycle, on the edge after the check.
- R3: A store disarms every armed entry whose address bits [31:3] equal the store's bits [31:3], so a partial overlap inside an 8-byte block counts as aliasing. A store to any other block leaves the entries untouched.
- R4: A check with `chk_branch`=0 that finds its entry disarmed pulses `reload_valid` on the next edge. `reload_reg` carries the checked register and `reload_addr` carries the recorded address.
- R5: A check with `chk_branch`=1 that finds aliasing pulses `redirect_valid` with `redirect_reg` equal to the checked register, and does not request a reload.
- R6: A check whose slot holds a different register (the entry was replaced by a colliding register, or was never written) is treated as aliased. In the reload case `reload_addr` is zero.
- R7: A new hoisted load replaces whatever its slot held and re-arms it, even when the previous entry had been disarmed by a store.
- R8: When a store and a hoisted load to the same 8-byte block arrive in the same cycle, the new entry stays armed.
- R9: A check sees the table as it stood before that cycle's store and hoisted load take effect.
- R10: A passing check leaves the entry armed, so a repeated check passes again. Every check produces exactly one of `chk_ok`, `reload_valid` or `redirect_valid`, each lasting one cycle; none of them rises without a check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adv_valid | input | 1 | Hoisted load arms an entry this cycle |
| adv_reg | input | REG_W | Destination register of the hoisted load |
| adv_addr | input | ADDR_W | Byte address read by the hoisted load |
| st_valid | input | 1 | Store observed this cycle |
| st_addr | input | ADDR_W | Byte address written by the store |
| chk_valid | input | 1 | Check request this cycle |
| chk_reg | input | REG_W | Register being checked |
| chk_branch | input | 1 | 1: redirect on aliasing, 0: reload on aliasing |
| chk_ok | output | 1 | Check retired as a no-op |
| reload_valid | output | 1 | Reload request pulse |
| reload_reg | output | REG_W | Register to reload (zero when idle) |
| reload_addr | output | ADDR_W | Address to reload from (zero when idle or unknown) |
| redirect_valid | output | 1 | Redirect-to-recovery pulse |
| redirect_reg | output | REG_W | Register whose check failed (zero when idle) |

## Verification
Three pairs of events can fall in the same cycle. A store can land in the same 8-byte block as a hoisted load. A check can meet a store that hits its own entry. A check can meet a new hoisted load to the same slot. The bench sets up each of these on purpose. After that, a long random phase draws registers and addresses from small pools, including colliding registers, so these pairings keep recurring. Every output is judged each clock against a behavioural table model. In that model, the store's effect is applied before the allocation in the same cycle. The check's answer is always taken from the state at the start of the cycle.

// File: rtl/alias_tbl_pkg.sv
// Package: shared types for the advanced load alias table.
// Assumes nothing beyond IEEE 1800-2017 enumerations.
package alias_tbl_pkg;

    // Outcome of one check request
    typedef enum logic [1:0] {
        VERDICT_NONE     = 2'd0,
        VERDICT_OK       = 2'd1,
        VERDICT_RELOAD   = 2'd2,
        VERDICT_REDIRECT = 2'd3
    } verdict_e;

endpackage

// File: rtl/alias_index_hash.sv
// Module: alias_index_hash
// Folds a register number into a slot index by XOR of IDX_W-bit chunks.
// Assumes REG_W >= 1 and IDX_W >= 1; purely combinational.
module alias_index_hash #(
    parameter int REG_W = 7,
    parameter int IDX_W = 4
) (
    input  logic [REG_W-1:0] reg_i,
    output logic [IDX_W-1:0] idx_o
);
    localparam int FOLDS = (REG_W + IDX_W - 1) / IDX_W;
    localparam int PAD_W = FOLDS * IDX_W;

    logic [PAD_W-1:0] padded;

    // Zero-extend the register number to a whole number of chunks
    always_comb begin
        padded = '0;
        padded[REG_W-1:0] = reg_i;
    end

    // XOR all chunks together
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < FOLDS; i++) begin
            idx_o = idx_o ^ padded[i*IDX_W +: IDX_W];
        end
    end
endmodule

// File: rtl/alias_entry.sv
// Module: alias_entry
// One slot of the table: holds armed bit, register tag and recorded address.
// A store to the same aligned block disarms it unless the slot is being
// written in the same cycle (allocation wins). Assumes synchronous reset.
module alias_entry #(
    parameter int REG_W     = 7,
    parameter int ADDR_W    = 32,
    parameter int BLK_SHIFT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic [REG_W-1:0]  alloc_reg,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    output logic              valid_o,
    output logic [REG_W-1:0]  tag_o,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int BLK_W = ADDR_W - BLK_SHIFT;

    logic [BLK_W-1:0] own_blk;
    logic [BLK_W-1:0] st_blk;
    logic             st_hit;

    // Block numbers of the recorded address and of the store
    always_comb begin
        own_blk = addr_o[ADDR_W-1:BLK_SHIFT];
        st_blk  = st_addr[ADDR_W-1:BLK_SHIFT];
        st_hit  = st_valid && valid_o && (own_blk == st_blk);
    end

    // Slot state: allocate, or disarm on an aliasing store
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            tag_o   <= '0;
            addr_o  <= '0;
        end else if (alloc_en) begin
            valid_o <= 1'b1;
            tag_o   <= alloc_reg;
            addr_o  <= alloc_addr;
        end else if (st_hit) begin
            valid_o <= 1'b0;
        end
    end

    AST_ALLOC_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |=> (valid_o && tag_o == $past(alloc_reg) && addr_o == $past(alloc_addr))); // R2
    AST_STORE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && valid_o && !alloc_en && addr_o[ADDR_W-1:BLK_SHIFT] == st_addr[ADDR_W-1:BLK_SHIFT]) |=> !valid_o); // R3
    AST_ALLOC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_en && st_valid && alloc_addr[ADDR_W-1:BLK_SHIFT] == st_addr[ADDR_W-1:BLK_SHIFT]) |=> valid_o); // R8
endmodule

// File: rtl/alias_check_resolve.sv
// Module: alias_check_resolve
// Turns a check request and the selected slot into a registered verdict:
// no-op, reload or redirect, each a one-cycle pulse. Assumes the slot
// contents presented are those from before this cycle's updates.
module alias_check_resolve
    import alias_tbl_pkg::*;
#(
    parameter int REG_W  = 7,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_valid,
    input  logic [REG_W-1:0]  chk_reg,
    input  logic              chk_branch,
    input  logic              sel_valid,
    input  logic [REG_W-1:0]  sel_tag,
    input  logic [ADDR_W-1:0] sel_addr,
    output logic              ok_o,
    output logic              reload_o,
    output logic [REG_W-1:0]  reload_reg_o,
    output logic [ADDR_W-1:0] reload_addr_o,
    output logic              redirect_o,
    output logic [REG_W-1:0]  redirect_reg_o
);
    verdict_e         verdict;
    logic             tag_match;
    logic [ADDR_W-1:0] known_addr;

    // Decide the outcome of this cycle's check
    always_comb begin
        tag_match  = (sel_tag == chk_reg);
        known_addr = tag_match ? sel_addr : '0;
        if (!chk_valid)                  verdict = VERDICT_NONE;
        else if (tag_match && sel_valid) verdict = VERDICT_OK;
        else if (chk_branch)             verdict = VERDICT_REDIRECT;
        else                             verdict = VERDICT_RELOAD;
    end

    // Register the verdict into single-cycle output pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok_o           <= 1'b0;
            reload_o       <= 1'b0;
            reload_reg_o   <= '0;
            reload_addr_o  <= '0;
            redirect_o     <= 1'b0;
            redirect_reg_o <= '0;
        end else begin
            ok_o           <= (verdict == VERDICT_OK);
            reload_o       <= (verdict == VERDICT_RELOAD);
            reload_reg_o   <= (verdict == VERDICT_RELOAD) ? chk_reg : '0;
            reload_addr_o  <= (verdict == VERDICT_RELOAD) ? known_addr : '0;
            redirect_o     <= (verdict == VERDICT_REDIRECT);
            redirect_reg_o <= (verdict == VERDICT_REDIRECT) ? chk_reg : '0;
        end
    end

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ok_o, reload_o, redirect_o})); // R10
    AST_PULSE_NEEDS_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_o || reload_o || redirect_o) |-> $past(chk_valid)); // R10
    AST_REDIRECT_ONLY_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> $past(chk_branch)); // R5
    AST_RELOAD_ONLY_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        reload_o |-> !$past(chk_branch)); // R4
endmodule

// File: rtl/adv_load_alias_table.sv
// Module: adv_load_alias_table (top)
// Table of hoisted loads indexed by a fold of the destination register.
// Stores disarm matching 8-byte blocks; checks answer with no-op, reload
// or redirect one cycle later. Assumes one request of each kind per cycle.
module adv_load_alias_table #(
    parameter int REG_W     = 7,
    parameter int ADDR_W    = 32,
    parameter int IDX_W     = 4,
    parameter int BLK_SHIFT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_valid,
    input  logic [REG_W-1:0]  adv_reg,
    input  logic [ADDR_W-1:0] adv_addr,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              chk_valid,
    input  logic [REG_W-1:0]  chk_reg,
    input  logic              chk_branch,
    output logic              chk_ok,
    output logic              reload_valid,
    output logic [REG_W-1:0]  reload_reg,
    output logic [ADDR_W-1:0] reload_addr,
    output logic              redirect_valid,
    output logic [REG_W-1:0]  redirect_reg
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [IDX_W-1:0]  adv_idx;
    logic [IDX_W-1:0]  chk_idx;
    logic [ENTRIES-1:0] ent_valid;
    logic [REG_W-1:0]  ent_tag  [ENTRIES];
    logic [ADDR_W-1:0] ent_addr [ENTRIES];
    logic              sel_valid;
    logic [REG_W-1:0]  sel_tag;
    logic [ADDR_W-1:0] sel_addr;

    alias_index_hash #(.REG_W(REG_W), .IDX_W(IDX_W)) u_hash_adv (
        .reg_i (adv_reg),
        .idx_o (adv_idx)
    );

    alias_index_hash #(.REG_W(REG_W), .IDX_W(IDX_W)) u_hash_chk (
        .reg_i (chk_reg),
        .idx_o (chk_idx)
    );

    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
        alias_entry #(
            .REG_W     (REG_W),
            .ADDR_W    (ADDR_W),
            .BLK_SHIFT (BLK_SHIFT)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_en   (adv_valid && (adv_idx == IDX_W'(e))),
            .alloc_reg  (adv_reg),
            .alloc_addr (adv_addr),
            .st_valid   (st_valid),
            .st_addr    (st_addr),
            .valid_o    (ent_valid[e]),
            .tag_o      (ent_tag[e]),
            .addr_o     (ent_addr[e])
        );
    end

    // Read the slot named by the check
    always_comb begin
        sel_valid = ent_valid[chk_idx];
        sel_tag   = ent_tag[chk_idx];
        sel_addr  = ent_addr[chk_idx];
    end

    alias_check_resolve #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_resolve (
        .clk            (clk),
        .rst_n          (rst_n),
        .chk_valid      (chk_valid),
        .chk_reg        (chk_reg),
        .chk_branch     (chk_branch),
        .sel_valid      (sel_valid),
        .sel_tag        (sel_tag),
        .sel_addr       (sel_addr),
        .ok_o           (chk_ok),
        .reload_o       (reload_valid),
        .reload_reg_o   (reload_reg),
        .reload_addr_o  (reload_addr),
        .redirect_o     (redirect_valid),
        .redirect_reg_o (redirect_reg)
    );

    AST_CHECK_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> (chk_ok || reload_valid || redirect_valid)); // R10
    AST_ANSWER_REG: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_valid || redirect_valid) |-> ((reload_reg | redirect_reg) == $past(chk_reg))); // R4
endmodule

// File: tb/sim_adv_load_alias_table.sv
module sim_adv_load_alias_table;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        adv_valid, st_valid, chk_valid, chk_branch;
    logic [6:0]  adv_reg, chk_reg;
    logic [31:0] adv_addr, st_addr;
    logic        chk_ok, reload_valid, redirect_valid;
    logic [6:0]  reload_reg, redirect_reg;
    logic [31:0] reload_addr;

    int n_cmp = 0;
    int n_bad = 0;

    // behavioural model
    bit          m_valid [16];
    int          m_tag   [16];
    logic [31:0] m_addr  [16];
    bit          e_ok, e_rl, e_rd;
    int          e_rl_reg, e_rd_reg;
    logic [31:0] e_rl_addr;

    always #5 clk = ~clk;

    adv_load_alias_table u0 (
        .clk(clk), .rst_n(rst_n),
        .adv_valid(adv_valid), .adv_reg(adv_reg), .adv_addr(adv_addr),
        .st_valid(st_valid), .st_addr(st_addr),
        .chk_valid(chk_valid), .chk_reg(chk_reg), .chk_branch(chk_branch),
        .chk_ok(chk_ok), .reload_valid(reload_valid), .reload_reg(reload_reg),
        .reload_addr(reload_addr), .redirect_valid(redirect_valid),
        .redirect_reg(redirect_reg)
    );

    function automatic int slot_of(int r);
        return (r % 16) ^ (r / 16);
    endfunction

    task automatic compare(string req);
        n_cmp++;
        if (chk_ok !== e_ok) begin
            n_bad++; $display("FAIL %s chk_ok actual=%0b expected=%0b", req, chk_ok, e_ok);
        end
        if (reload_valid !== e_rl) begin
            n_bad++; $display("FAIL %s reload_valid actual=%0b expected=%0b", req, reload_valid, e_rl);
        end
        if (reload_reg !== 7'(e_rl_reg)) begin
            n_bad++; $display("FAIL %s reload_reg actual=%0d expected=%0d", req, reload_reg, e_rl_reg);
        end
        if (reload_addr !== e_rl_addr) begin
            n_bad++; $display("FAIL %s reload_addr actual=%h expected=%h", req, reload_addr, e_rl_addr);
        end
        if (redirect_valid !== e_rd) begin
            n_bad++; $display("FAIL %s redirect_valid actual=%0b expected=%0b", req, redirect_valid, e_rd);
        end
        if (redirect_reg !== 7'(e_rd_reg)) begin
            n_bad++; $display("FAIL %s redirect_reg actual=%0d expected=%0d", req, redirect_reg, e_rd_reg);
        end
    endtask

    // One cycle: drive at negedge, predict, update model, check at next negedge
    task automatic cyc(bit av, int ar, logic [31:0] aa, bit sv, logic [31:0] sa,
                       bit cv, int cr, bit cb, string req);
        int ci, ai;
        adv_valid = av; adv_reg = 7'(ar); adv_addr = aa;
        st_valid = sv; st_addr = sa;
        chk_valid = cv; chk_reg = 7'(cr); chk_branch = cb;
        e_ok = 0; e_rl = 0; e_rd = 0; e_rl_reg = 0; e_rd_reg = 0; e_rl_addr = '0;
        if (cv) begin
            ci = slot_of(cr);
            if (m_tag[ci] == cr && m_valid[ci]) e_ok = 1;
            else if (cb) begin e_rd = 1; e_rd_reg = cr; end
            else begin
                e_rl = 1; e_rl_reg = cr;
                e_rl_addr = (m_tag[ci] == cr) ? m_addr[ci] : 32'h0;
            end
        end
        ai = av ? slot_of(ar) : -1;
        for (int e = 0; e < 16; e++) begin
            if (sv && m_valid[e] && (m_addr[e] >> 3) == (sa >> 3) && e != ai) m_valid[e] = 0;
        end
        if (av) begin m_valid[ai] = 1; m_tag[ai] = ar; m_addr[ai] = aa; end
        @(negedge clk);
        compare(req);
    endtask

    task automatic chk(int r, bit b, string req);
        cyc(0, 0, 0, 0, 0, 1, r, b, req);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        for (int e = 0; e < 16; e++) begin m_valid[e] = 0; m_tag[e] = 0; m_addr[e] = 0; end
        rst_n = 0;
        adv_valid = 0; st_valid = 0; chk_valid = 0; chk_branch = 0;
        adv_reg = 0; chk_reg = 0; adv_addr = 0; st_addr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        e_ok = 0; e_rl = 0; e_rd = 0; e_rl_reg = 0; e_rd_reg = 0; e_rl_addr = 0;
        compare("R1 reset outputs");
        chk(5, 0, "R1 check after reset reloads");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, "R1 idle");

        // R2 arm and pass; R10 repeat pass
        cyc(1, 5, 32'h1000, 0, 0, 0, 0, 0, "R2 arm");
        chk(5, 0, "R2 clean check");
        chk(5, 0, "R10 repeat check still passes");

        // R3 partial overlap disarms; R4 reload with recorded address
        cyc(1, 6, 32'h2000, 0, 0, 0, 0, 0, "R3 arm");
        cyc(0, 0, 0, 1, 32'h2004, 0, 0, 0, "R3 overlapping store");
        chk(6, 0, "R4 reload after alias");
        cyc(0, 0, 0, 1, 32'h1008, 0, 0, 0, "R3 other-block store");
        chk(5, 0, "R3 untouched entry passes");

        // R5 redirect variant
        cyc(1, 7, 32'h3000, 0, 0, 0, 0, 0, "R5 arm");
        cyc(0, 0, 0, 1, 32'h3007, 0, 0, 0, "R5 store");
        chk(7, 1, "R5 redirect");

        // R6 colliding register replaces slot
        cyc(1, 1, 32'h4000, 0, 0, 0, 0, 0, "R6 arm r1");
        cyc(1, 16, 32'h5000, 0, 0, 0, 0, 0, "R6 arm colliding r16");
        chk(1, 0, "R6 evicted reload with zero address");
        chk(1, 1, "R6 evicted redirect");
        chk(16, 0, "R6 replacement passes");

        // R7 re-arm after alias
        cyc(1, 6, 32'h2010, 0, 0, 0, 0, 0, "R7 re-arm");
        chk(6, 0, "R7 re-armed passes");

        // R8 same-cycle store and alloc
        cyc(1, 8, 32'h6000, 1, 32'h6003, 0, 0, 0, "R8 alloc with store");
        chk(8, 0, "R8 allocation wins");

        // R9 check sees pre-cycle state
        cyc(0, 0, 0, 1, 32'h1000, 1, 5, 0, "R9 check with aliasing store");
        chk(5, 0, "R9 store now visible");
        cyc(1, 9, 32'h7000, 0, 0, 1, 9, 0, "R9 check with same-cycle alloc");
        chk(9, 0, "R9 alloc now visible");

        // Random phase on small pools
        for (int i = 0; i < 4000; i++) begin
            int pool_r [8] = '{0, 1, 2, 3, 16, 17, 18, 5};
            bit av, sv, cv, cb;
            int ar, cr;
            logic [31:0] aa, sa;
            av = ($urandom % 3) == 0;
            sv = ($urandom % 2) == 0;
            cv = ($urandom % 2) == 0;
            cb = ($urandom % 2) == 0;
            ar = pool_r[$urandom % 8];
            cr = pool_r[$urandom % 8];
            aa = 32'h8000 + (($urandom % 8) << 3) + ($urandom % 8);
            sa = 32'h8000 + (($urandom % 8) << 3) + ($urandom % 8);
            cyc(av, ar, aa, sv, sa, cv, cr, cb, "R10 random mix");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule